// File: doc/BRIEF.md
# Unaligned Access Splitter

This block sits between a load/store requester and a 32-bit, byte-addressed data bus. It accepts one request at a time: a byte address, a width of 1, 2, 4 or 8 bytes, a direction, a byte-order select and up to 64 bits of store data. It turns the request into a series of naturally aligned bus transfers. Each transfer has its own address, size and lane enables. For loads it gathers the returned bytes into one result in the requested byte order. Aligned and unaligned requests are handled the same way in both byte orders. An unaligned request simply needs more transfers.

A fault-enable input is sampled when a request is accepted. If it is set and the request was not on the natural boundary of its width, the response carries a fault flag. The access itself is still performed in full before the flag appears.

The request side and the response side are valid/ready streams. A request is taken only in a cycle where `req_ready` and `req_valid` are both high. The response stays valid, and holds every field steady, until `rsp_ready` is seen high. The bus side is also a valid/ready pair. A transfer holds all of its fields while `bus_ready` is low. `bus_ready` both completes the transfer and qualifies `bus_rdata` in that same cycle. `busy` is a plain status pin.

Top module: `ua_split_top`

## Requirements
- R1: `req_ready` is high exactly when the block is idle; `busy` is its complement. No request is accepted from acceptance until the response handshake completes, even if `req_valid` stays high.
- R2: Request size codes are 0=1 byte, 1=2 bytes, 2=4 bytes and 3=8 bytes. Bus size codes are 0=1, 1=2 and 2=4 bytes, and code 3 never appears. Every bus transfer address is a multiple of its size, so a transfer never leaves one 4-byte word.
- R3: Transfers are issued in ascending, gap-free address order from the request address. Each one is the largest of 4, 2 or 1 bytes that is aligned at the current address and not larger than the bytes still left. So an aligned word takes 1 transfer, an aligned 8-byte access takes 2, a word at offset 3 takes 3 (1,2,1 bytes) and an 8-byte access at offset 1 takes 4 (1,2,4,1 bytes).
- R4: The byte at address x travels on lane x mod 4, which is `bus_wdata`/`bus_rdata` bits 8*(x mod 4)+7 down to 8*(x mod 4). A `bus_be` bit is set exactly for the lanes the transfer carries.
- R5: Stores, little-endian: the memory byte at request address + k is `req_wdata` byte k (bits 8k+7:8k). Big-endian: it is byte W-1-k, where W is the width in bytes.
- R6: Loads are merged with the same mapping as R5 into `rsp_rdata`. Bytes at and above W are zero, and `rsp_rdata` is zero for stores. Lanes whose enable is clear are ignored.
- R7: While `bus_valid` is high and `bus_ready` is low, `bus_valid`, `bus_addr`, `bus_size`, `bus_be` and `bus_wdata` hold steady.
- R8: `rsp_valid` rises in the cycle after the last transfer is acknowledged. It holds, with steady `rsp_rdata` and `rsp_fault`, until `rsp_ready`, and the block is idle in the next cycle.
- R9: `rsp_fault` is high with the response only if `cfg_fault_en` was high when the request was accepted and the address was not a multiple of the width. Later changes of `cfg_fault_en` have no effect. A faulting request still performs all of its transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request may be taken |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 2 | Width code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_write | input | 1 | 1 = store, 0 = load |
| req_big | input | 1 | 1 = big-endian byte order |
| req_wdata | input | 64 | Store value, low W bytes used |
| cfg_fault_en | input | 1 | Raise fault on unaligned requests |
| bus_valid | output | 1 | Transfer offered |
| bus_ready | input | 1 | Transfer accepted, read lanes valid |
| bus_addr | output | ADDR_W | Transfer byte address |
| bus_size | output | 2 | Transfer size code: 0=1, 1=2, 2=4 bytes |
| bus_be | output | 4 | Lane enables |
| bus_write | output | 1 | Transfer direction |
| bus_wdata | output | 32 | Store lanes |
| bus_rdata | input | 32 | Load lanes |
| rsp_valid | output | 1 | Result ready |
| rsp_ready | input | 1 | Result taken |
| rsp_rdata | output | 64 | Merged load result |
| rsp_fault | output | 1 | Unaligned-operation fault |
| busy | output | 1 | Request in progress |

## Verification
Two events can share one cycle: the last bus acknowledge of a request, and a new request that is already waiting at the input. The bench provokes this by keeping `req_valid` high with a complete request from acceptance, through the final transfer and through a response held back by `rsp_ready`. It then drops the request in the cycle the block returns to idle. The result is judged by three things: `req_ready` stays low throughout, the transfer count equals the split rule's count, and no further transfer appears after the response handshake. Separately, back-pressure on single transfers is checked against field stability, and a toggle of `cfg_fault_en` after acceptance is checked against the fault flag.

// File: rtl/ua_split_pkg.sv
package ua_split_pkg;
  localparam int LANES     = 4;               // bus lanes (32-bit bus)
  localparam int MAX_BYTES = 8;               // widest request
  localparam int LANE_IW   = $clog2(MAX_BYTES);

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_H = 2'd1,
    SZ_W = 2'd2,
    SZ_D = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_RESP = 2'd2
  } split_state_e;

  // byte count of a size code
  function automatic logic [3:0] size_bytes(input logic [1:0] sz);
    return 4'd1 << sz;
  endfunction
endpackage

// File: rtl/ua_xfer_plan.sv
// Picks the next naturally aligned transfer: the largest of 4/2/1 bytes
// aligned at the current address and no larger than what is left.
module ua_xfer_plan
  import ua_split_pkg::*;
(
  input  logic [1:0] lo,       // current address within the word
  input  logic [3:0] rem,      // bytes still to move
  output logic [1:0] sz,       // bus size code
  output logic [2:0] nbytes,   // bytes in this transfer
  output logic [3:0] be        // lane enables
);
  logic [3:0] mask;

  always_comb begin
    if (lo == 2'd0 && rem >= 4'd4)      sz = SZ_W;
    else if (!lo[0] && rem >= 4'd2)     sz = SZ_H;
    else                                sz = SZ_B;
  end

  assign nbytes = 3'd1 << sz;

  always_comb begin
    unique case (sz)
      SZ_W:    mask = 4'b1111;
      SZ_H:    mask = 4'b0011;
      default: mask = 4'b0001;
    endcase
  end

  assign be = mask << lo;
endmodule

// File: rtl/ua_lane_map.sv
// Per lane: which byte of the request value the lane carries, given the
// byte order, and the store lane data.
module ua_lane_map
  import ua_split_pkg::*;
(
  input  logic [1:0]                      lo,
  input  logic [3:0]                      be,
  input  logic [LANE_IW-1:0]              kbase,   // request bytes already moved
  input  logic [3:0]                      wbytes,  // request width in bytes
  input  logic                            big,
  input  logic [8*MAX_BYTES-1:0]          wdata,
  output logic [LANES-1:0][LANE_IW-1:0]   lane_idx,
  output logic [8*LANES-1:0]              lane_wdata
);
  logic [LANE_IW-1:0] top_idx;
  assign top_idx = LANE_IW'(wbytes - 4'd1);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_IW-1:0] k;   // memory-order byte position within request
    assign k = kbase + LANE_IW'(j) - LANE_IW'(lo);
    assign lane_idx[j] = big ? (top_idx - k) : k;
    assign lane_wdata[8*j +: 8] = be[j] ? wdata[{lane_idx[j], 3'b000} +: 8] : 8'h00;
  end
endmodule

// File: rtl/ua_read_merge.sv
// Accumulates enabled load lanes into their value byte positions.
module ua_read_merge
  import ua_split_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clear,
  input  logic                            capture,
  input  logic [LANES-1:0]                be,
  input  logic [LANES-1:0][LANE_IW-1:0]   lane_idx,
  input  logic [8*LANES-1:0]              rdata,
  output logic [8*MAX_BYTES-1:0]          acc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      acc <= '0;
    end else if (capture) begin
      for (int j = 0; j < LANES; j++) begin
        if (be[j]) acc[{lane_idx[j], 3'b000} +: 8] <= rdata[8*j +: 8];
      end
    end
  end
endmodule

// File: rtl/ua_split_top.sv
module ua_split_top
  import ua_split_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic              req_big,
  input  logic [63:0]       req_wdata,
  input  logic              cfg_fault_en,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_size,
  output logic [3:0]        bus_be,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_fault,
  output logic              busy
);
  split_state_e         state;
  logic [ADDR_W-1:0]    cur_addr;
  logic [3:0]           rem;
  logic [3:0]           wbytes;
  logic [LANE_IW-1:0]   kdone;
  logic                 write_q, big_q, fault_q;
  logic [63:0]          wdata_q;

  logic [1:0]           p_sz;
  logic [2:0]           p_n;
  logic [3:0]           p_be;
  logic [LANES-1:0][LANE_IW-1:0] lane_idx;

  logic accept, xfer_done, last_xfer;
  logic [3:0] req_bytes;
  logic       req_unaligned;

  assign accept    = req_valid && req_ready;
  assign xfer_done = bus_valid && bus_ready;
  assign last_xfer = (rem == {1'b0, p_n});

  assign req_bytes     = size_bytes(req_size);
  assign req_unaligned = (req_addr[2:0] & (3'(req_bytes) - 3'd1)) != 3'd0;

  // ---------------- control ----------------
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      wbytes   <= '0;
      kdone    <= '0;
      write_q  <= 1'b0;
      big_q    <= 1'b0;
      fault_q  <= 1'b0;
      wdata_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_XFER;
          cur_addr <= req_addr;
          rem      <= req_bytes;
          wbytes   <= req_bytes;
          kdone    <= '0;
          write_q  <= req_write;
          big_q    <= req_big;
          wdata_q  <= req_wdata;
          fault_q  <= cfg_fault_en && req_unaligned;   // R9 sampled here
        end
        ST_XFER: if (xfer_done) begin
          cur_addr <= cur_addr + ADDR_W'(p_n);
          rem      <= rem - {1'b0, p_n};
          kdone    <= kdone + LANE_IW'(p_n);
          if (last_xfer) state <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // ---------------- datapath ----------------
  ua_xfer_plan u_plan (
    .lo     (cur_addr[1:0]),
    .rem    (rem),
    .sz     (p_sz),
    .nbytes (p_n),
    .be     (p_be)
  );

  ua_lane_map u_map (
    .lo         (cur_addr[1:0]),
    .be         (p_be),
    .kbase      (kdone),
    .wbytes     (wbytes),
    .big        (big_q),
    .wdata      (wdata_q),
    .lane_idx   (lane_idx),
    .lane_wdata (bus_wdata)
  );

  ua_read_merge u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .capture  (xfer_done && !write_q),
    .be       (p_be),
    .lane_idx (lane_idx),
    .rdata    (bus_rdata),
    .acc      (rsp_rdata)
  );

  assign req_ready = (state == ST_IDLE);
  assign busy      = !req_ready;
  assign bus_valid = (state == ST_XFER);
  assign bus_addr  = cur_addr;
  assign bus_size  = p_sz;
  assign bus_be    = p_be;
  assign bus_write = write_q;
  assign rsp_valid = (state == ST_RESP);
  assign rsp_fault = rsp_valid && fault_q;

  // ---------------- assertions ----------------
  logic              seen_xfer;
  logic [ADDR_W-1:0] next_exp;
  always_ff @(posedge clk) begin
    if (!rst_n || accept) begin
      seen_xfer <= 1'b0;
      next_exp  <= '0;
    end else if (xfer_done) begin
      seen_xfer <= 1'b1;
      next_exp  <= bus_addr + ADDR_W'(1 << bus_size);
    end
  end

  assert_no_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid || rsp_valid) |-> (!req_ready && busy));

  assert_aligned_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_size != 2'd3) && (bus_size != SZ_H || !bus_addr[0]) &&
                  (bus_size != SZ_W || bus_addr[1:0] == 2'd0));

  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && seen_xfer) |-> (bus_addr == next_exp));

  assert_lane_enables_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(bus_be) == (1 << bus_size)) && bus_be[bus_addr[1:0]]);

  assert_bus_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_addr) && $stable(bus_be) &&
                                  $stable(bus_size) && $stable(bus_wdata));

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_rdata) && $stable(rsp_fault));

  assert_fault_with_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid);
endmodule

// File: tb/test_ua_split_top.sv
`timescale 1ns/100ps
module test_ua_split_top;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, req_big = 1'b0, cfg_fault_en = 1'b0;
  logic          req_ready, bus_valid, bus_write, rsp_valid, rsp_fault, busy;
  logic [AW-1:0] req_addr = '0, bus_addr;
  logic [1:0]    req_size = '0, bus_size;
  logic [63:0]   req_wdata = '0, rsp_rdata;
  logic [3:0]    bus_be;
  logic [31:0]   bus_wdata, bus_rdata = '0;
  logic          bus_ready = 1'b0, rsp_ready = 1'b0;

  always #2.5 clk = ~clk;   // 200 MHz

  ua_split_top #(.ADDR_W(AW)) i_ua_split_top (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_big(req_big), .req_wdata(req_wdata), .cfg_fault_en(cfg_fault_en),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_be(bus_be), .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_fault(rsp_fault),
    .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [7:0] mem  [0:255];   // bus-side memory
  logic [7:0] emem [0:255];   // expected memory image

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL R1 watchdog expired actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // One complete access, checked against the requirement rules.
  task automatic run_access(input logic [7:0] a, input logic [1:0] sz, input bit wr,
                            input bit big, input logic [63:0] wd, input bit fen,
                            input bit stall, input bit hold, input int exp_n,
                            input bit exp_fault, input string name);
    int w;
    int n;
    int rem;
    int guard;
    logic [7:0]  cur;
    logic [63:0] exp_rd;
    logic [1:0]  esz;
    logic [3:0]  ebe;
    logic [AW-1:0] held_addr;
    int          mism;
    w = 1 << sz;
    n = 0;
    rem = w;
    cur = a;
    exp_rd = '0;
    for (int k = 0; k < w; k++) begin
      int vi;
      vi = big ? (w - 1 - k) : k;
      exp_rd[8*vi +: 8] = mem[int'(a) + k];
      if (wr) emem[int'(a) + k] = wd[8*vi +: 8];
    end
    if (wr) exp_rd = '0;

    check(req_ready == 1'b1, "R1", {name, " ready when idle"}, 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = AW'(a); req_size = sz; req_write = wr;
    req_big = big; req_wdata = wd; cfg_fault_en = fen;
    step();
    if (!hold) req_valid = 1'b0;
    cfg_fault_en = !fen;                 // R9: must not matter any more
    guard = 0;
    while (!rsp_valid && guard < 40) begin
      guard++;
      check(!req_ready && busy, "R1", {name, " ready while busy"}, 64'(req_ready), 64'd0);
      if (bus_valid) begin
        if (cur[1:0] == 2'd0 && rem >= 4) esz = 2'd2;
        else if (!cur[0] && rem >= 2)     esz = 2'd1;
        else                              esz = 2'd0;
        ebe = (esz == 2'd2) ? 4'hF : ((esz == 2'd1) ? 4'h3 : 4'h1);
        ebe = ebe << cur[1:0];
        check(bus_addr == AW'(cur) && bus_size == esz, "R3", {name, " transfer addr/size"},
              {30'd0, bus_addr, bus_size}, {30'd0, AW'(cur), esz});
        check(bus_be == ebe && bus_write == wr, "R4", {name, " lane enables"},
              64'(bus_be), 64'(ebe));
        if (stall) begin
          held_addr = bus_addr;
          bus_ready = 1'b0;
          step();
          check(bus_valid && bus_addr == held_addr && bus_be == ebe, "R7",
                {name, " hold under back-pressure"}, 64'(bus_addr), 64'(held_addr));
        end
        for (int j = 0; j < 4; j++) begin
          int idx;
          idx = int'(cur[7:2]) * 4 + j;
          bus_rdata[8*j +: 8] = mem[idx];
          if (wr && ebe[j]) mem[idx] = bus_wdata[8*j +: 8];
        end
        bus_ready = 1'b1;
        step();
        bus_ready = 1'b0;
        bus_rdata = 32'hDEAD_BEEF;
        n++;
        rem = rem - (1 << esz);
        cur = cur + 8'(1 << esz);
      end else begin
        step();
      end
    end
    check(rsp_valid, "R8", {name, " response after last transfer"}, 64'(rsp_valid), 64'd1);
    check(n == exp_n, "R3", {name, " transfer count"}, 64'(n), 64'(exp_n));
    check(rsp_rdata == exp_rd, "R6", {name, " merged result"}, rsp_rdata, exp_rd);
    check(rsp_fault == exp_fault, "R9", {name, " fault flag"}, 64'(rsp_fault), 64'(exp_fault));
    if (hold) begin
      rsp_ready = 1'b0;
      step();
      check(rsp_valid && rsp_rdata == exp_rd && !req_ready, "R8", {name, " response held"},
            rsp_rdata, exp_rd);
    end
    rsp_ready = 1'b1;
    step();
    rsp_ready = 1'b0;
    req_valid = 1'b0;
    check(!rsp_valid && req_ready, "R8", {name, " idle after response"}, 64'(rsp_valid), 64'd0);
    step();
    check(!bus_valid, "R1", {name, " no extra transfer"}, 64'(bus_valid), 64'd0);
    if (wr) begin
      mism = 0;
      for (int i = 0; i < 256; i++) if (mem[i] != emem[i]) mism++;
      check(mism == 0, "R5", {name, " stored bytes"}, 64'(mism), 64'd0);
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < 256; i++) begin
      mem[i]  = 8'((i * 37 + 11) & 255);
      emem[i] = mem[i];
    end
    rst_n = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    check(req_ready && !busy && !bus_valid && !rsp_valid, "R1", "reset state",
          {60'd0, req_ready, busy, bus_valid, rsp_valid}, 64'h8);
  endtask

  task automatic t_aligned_words();
    run_access(8'd8, 2'd2, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R6 word LE");
    run_access(8'd8, 2'd2, 1'b0, 1'b1, 64'd0, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R6 word BE");
  endtask

  task automatic t_dword_misaligned();
    run_access(8'd1, 2'd3, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 4, 1'b1, "R3 dword@1 LE");
    run_access(8'd9, 2'd3, 1'b0, 1'b1, 64'd0, 1'b1, 1'b1, 1'b0, 4, 1'b1, "R7 dword@9 BE stall");
  endtask

  task automatic t_stores();
    run_access(8'd3, 2'd2, 1'b1, 1'b1, 64'h0000_0000_A1B2_C3D4, 1'b0, 1'b0, 1'b0, 3, 1'b0,
               "R5 word@3 BE store");
    run_access(8'd5, 2'd1, 1'b1, 1'b0, 64'h0000_0000_0000_5A6B, 1'b1, 1'b1, 1'b0, 2, 1'b1,
               "R5 half@5 LE store");
    run_access(8'd4, 2'd3, 1'b1, 1'b1, 64'h1122_3344_5566_7788, 1'b1, 1'b0, 1'b0, 2, 1'b1,
               "R5 dword@4 BE store");
  endtask

  task automatic t_fault_rules();
    run_access(8'd7,  2'd0, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1, 1'b0, "R9 byte never faults");
    run_access(8'd16, 2'd3, 1'b0, 1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 2, 1'b0, "R9 aligned dword");
    run_access(8'd6,  2'd2, 1'b0, 1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 2, 1'b0, "R9 fault disabled");
  endtask

  task automatic t_held_request();
    run_access(8'd6, 2'd1, 1'b0, 1'b1, 64'd0, 1'b0, 1'b0, 1'b1, 1, 1'b0, "R1 held half BE");
    run_access(8'd2, 2'd2, 1'b0, 1'b0, 64'd0, 1'b1, 1'b1, 1'b1, 2, 1'b1, "R8 held word@2 LE");
  endtask

  initial begin
    t_reset();
    t_aligned_words();
    t_dword_misaligned();
    t_stores();
    t_fault_rules();
    t_held_request();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule